// File: doc/BRIEF.md
# Carry-Skip Adder/Subtractor with Group Bypass

This block is a purely combinational adder/subtractor of parameterised width. The operand bits are divided into consecutive groups. Within a group the carry ripples bit by bit. Next to each group sits a bypass path: when every bit of the group propagates, the group's outgoing carry is taken directly from its incoming carry through a multiplexer. Otherwise the group's outgoing carry is the carry that the group itself creates or absorbs. This shortens the worst carry path to one ripple in the first group, a chain of bypass hops, and one ripple in the last group.

Group sizes come from a parameter array, so the same source builds uniform layouts (four groups of four bits over 16 bits is the default) or non-uniform layouts with narrow end groups and wide middle groups. The entries of the array must add up to the operand width; if they do not, elaboration stops with an error. A mode input selects addition or subtraction. Subtraction is done by inverting the second operand and forcing the lowest carry to one. The carry-out then reads as "no borrow".

Top module: `csk_adder`

## Requirements
- R1: With `op_sub` = 0, `{co, sum}` equals `a + b + ci` taken as an unsigned (WIDTH+1)-bit value.
- R2: With `op_sub` = 1, `sum` equals `a - b` modulo 2^WIDTH.
- R3: With `op_sub` = 1, `co` is 1 exactly when `a >= b` as unsigned numbers (inverted borrow).
- R4: With `op_sub` = 1, `ci` has no effect: `sum` and `co` are the same for `ci` = 0 and `ci` = 1.
- R5: When every bit of a group propagates (each bit has a(i) XOR b'(i) = 1, where b' is `b` after the mode inversion), that group's carry-out equals its carry-in. This is checked at the ports with a = all ones, b = 0 in add mode: `ci` = 1 gives `sum` = 0 and `co` = 1, and `ci` = 0 gives `sum` = all ones and `co` = 0.
- R6: When a group has at least one bit that does not propagate, the group's carry-out is the carry the group generates internally. It does not depend on the group's carry-in.
- R7: Per bit, generate is a(i) AND b'(i), propagate is a(i) XOR b'(i), and kill is NOT a(i) AND NOT b'(i). Exactly one of the three is 1, and sum bit i is propagate XOR the carry into bit i.
- R8: The results of R1 to R4 hold for a non-uniform group layout (3, 5, 5, 3 over 16 bits) as well as for the uniform 4×4 layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| ci | input | 1 | Carry into bit 0 in add mode; ignored in subtract mode |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| sum | output | WIDTH | Sum or difference |
| co | output | 1 | Carry-out; in subtract mode 1 means no borrow |

## Verification
The in-RTL checks assume that all inputs carry known 0/1 values. Each check is skipped while any input it reads is unknown, so the period before the bench first drives the ports does not trip them. The stimulus always drives every input to a defined value, changes inputs only in the first half of a clock cycle, and reads results in the second half, so every check sees settled combinational values. The operand sets are directed corners (all-ones, zero, single-bit, per-group propagate and kill patterns) together with seeded random pairs, all applied in both modes.

// File: rtl/csk_pkg.sv
package csk_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_mode_e;

  function automatic logic bit_generate(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_propagate(input logic x, input logic y);
    return x ^ y;
  endfunction

  function automatic logic bit_kill(input logic x, input logic y);
    return ~x & ~y;
  endfunction

  function automatic logic sum_bit(input logic prop, input logic carry);
    return prop ^ carry;
  endfunction

  function automatic logic carry_next(input logic gen, input logic prop, input logic carry);
    return gen | (prop & carry);
  endfunction

endpackage

// File: rtl/csk_operand_prep.sv
module csk_operand_prep
  import csk_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  input  op_mode_e         mode,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] kill,
  output logic             c0
);

  logic [WIDTH-1:0] b_eff;

  assign b_eff = b ^ {WIDTH{mode == OP_SUB}};
  assign c0    = (mode == OP_SUB) ? 1'b1 : ci;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = bit_generate(a[i], b_eff[i]);
    assign prop[i] = bit_propagate(a[i], b_eff[i]);
    assign kill[i] = bit_kill(a[i], b_eff[i]);
  end

  // R7: the three per-bit carry states are exclusive and cover every case
  always_comb begin
    if (!$isunknown({a, b, mode})) begin
      p_gpk_exclusive_r7: assert ((gen & prop) == '0 && (gen & kill) == '0 && (prop & kill) == '0)
        else $error("generate/propagate/kill overlap");
      p_gpk_cover_r7: assert ((gen | prop | kill) == {WIDTH{1'b1}})
        else $error("bit with no carry state");
    end
  end

  // R4: subtract mode pins the low carry regardless of ci
  always_comb begin
    if (!$isunknown(mode)) begin
      p_sub_forces_c0_r4: assert (mode != OP_SUB || c0 == 1'b1)
        else $error("low carry not forced in subtract mode");
    end
  end

endmodule

// File: rtl/csk_group.sv
module csk_group
  import csk_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] gen,
  input  logic [GW-1:0] prop,
  input  logic          grp_cin,
  output logic [GW-1:0] bit_carry,
  output logic          grp_cout,
  output logic          grp_bypass
);

  logic [GW:0] ripple;

  assign ripple[0] = grp_cin;

  for (genvar i = 0; i < GW; i++) begin : g_ripple
    assign ripple[i+1] = carry_next(gen[i], prop[i], ripple[i]);
  end

  assign bit_carry  = ripple[GW-1:0];
  assign grp_bypass = &prop;
  assign grp_cout   = grp_bypass ? grp_cin : ripple[GW];

  // Carry this group produces on its own, with no carry arriving
  function automatic logic local_carry(input logic [GW-1:0] gg, input logic [GW-1:0] pp);
    logic acc;
    acc = 1'b0;
    for (int i = GW - 1; i >= 0; i--) begin
      if (!pp[i]) begin
        acc = gg[i];
        break;
      end
    end
    return acc;
  endfunction

  logic own_carry;
  assign own_carry = local_carry(gen, prop);

  always_comb begin
    if (!$isunknown({gen, prop, grp_cin})) begin
      p_bypass_passes_r5: assert (!grp_bypass || grp_cout == grp_cin)
        else $error("bypass group did not pass carry");
      p_block_owns_carry_r6: assert (grp_bypass || grp_cout == own_carry)
        else $error("non-bypass group carry depends on carry-in");
    end
  end

endmodule

// File: rtl/csk_sum_stage.sv
module csk_sum_stage
  import csk_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] carry,
  output logic [WIDTH-1:0] sum
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum[i] = sum_bit(prop[i], carry[i]);
  end

endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NGRP  = 4,
  parameter int GRP_SIZE [NGRP] = '{4, 4, 4, 4}
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  input  logic             op_sub,
  output logic [WIDTH-1:0] sum,
  output logic             co
);

  function automatic int grp_lsb(input int idx);
    int acc;
    acc = 0;
    for (int i = 0; i < idx; i++) acc += GRP_SIZE[i];
    return acc;
  endfunction

  localparam int TOTAL = grp_lsb(NGRP);

  if (TOTAL != WIDTH) begin : g_bad_layout
    $error("group sizes add to %0d, width is %0d", TOTAL, WIDTH);
  end

  op_mode_e         mode;
  logic [WIDTH-1:0] gen, prop, kill;
  logic [WIDTH-1:0] carry;
  logic [NGRP:0]    grp_carry;
  logic [NGRP-1:0]  grp_bypass;
  logic             c0;

  assign mode = op_sub ? OP_SUB : OP_ADD;

  csk_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .a    (a),
    .b    (b),
    .ci   (ci),
    .mode (mode),
    .gen  (gen),
    .prop (prop),
    .kill (kill),
    .c0   (c0)
  );

  assign grp_carry[0] = c0;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int LSB = grp_lsb(gi);
    localparam int GW  = GRP_SIZE[gi];

    csk_group #(.GW(GW)) u_grp (
      .gen        (gen[LSB +: GW]),
      .prop       (prop[LSB +: GW]),
      .grp_cin    (grp_carry[gi]),
      .bit_carry  (carry[LSB +: GW]),
      .grp_cout   (grp_carry[gi+1]),
      .grp_bypass (grp_bypass[gi])
    );
  end

  csk_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .prop  (prop),
    .carry (carry),
    .sum   (sum)
  );

  assign co = grp_carry[NGRP];

  // Behavioural cross-checks at the ports
  logic [WIDTH:0] ref_add;
  assign ref_add = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};

  always_comb begin
    if (!$isunknown({a, b, ci, op_sub})) begin
      p_add_result_r1: assert (op_sub || {co, sum} == ref_add)
        else $error("add result mismatch");
      p_sub_diff_r2: assert (!op_sub || sum == WIDTH'(a - b))
        else $error("difference mismatch");
      p_sub_noborrow_r3: assert (!op_sub || co == (a >= b))
        else $error("borrow flag mismatch");
      p_kill_blocks_bypass_r6: assert (kill == '0 || grp_bypass != {NGRP{1'b1}})
        else $error("bypass active with a killed bit");
    end
  end

endmodule

// File: tb/csk_adder_test.sv
`timescale 1ns/1ps
module csk_adder_test;

  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic         ci, op_sub;
  logic [W-1:0] sum_u, sum_v;
  logic         co_u, co_v;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  csk_adder #(.WIDTH(W), .NGRP(4), .GRP_SIZE('{4, 4, 4, 4})) uut (
    .a(a), .b(b), .ci(ci), .op_sub(op_sub), .sum(sum_u), .co(co_u)
  );

  csk_adder #(.WIDTH(W), .NGRP(4), .GRP_SIZE('{3, 5, 5, 3})) uut_var (
    .a(a), .b(b), .ci(ci), .op_sub(op_sub), .sum(sum_v), .co(co_v)
  );

  // Drive in the first half of a cycle, read in the second half
  task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic xc, input logic xs);
    @(posedge clk);
    a = xa; b = xb; ci = xc; op_sub = xs;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [W-1:0] es, input logic ec);
    n_tests++;
    if (sum_u !== es || co_u !== ec) begin
      n_fail++;
      $display("FAIL %s uniform: a=%h b=%h ci=%b sub=%b got sum=%h co=%b exp sum=%h co=%b",
               req, a, b, ci, op_sub, sum_u, co_u, es, ec);
    end
    n_tests++;
    if (sum_v !== es || co_v !== ec) begin
      n_fail++;
      $display("FAIL %s R8 non-uniform: a=%h b=%h ci=%b sub=%b got sum=%h co=%b exp sum=%h co=%b",
               req, a, b, ci, op_sub, sum_v, co_v, es, ec);
    end
  endtask

  // Reference written from the requirements: add as wide integers, subtract as difference and compare
  task automatic run_add(input string req, input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc);
    int unsigned tot;
    apply(xa, xb, xc, 1'b0);
    tot = int'(xa) + int'(xb) + int'(xc);
    expect_out(req, tot[W-1:0], tot[W]);
  endtask

  task automatic run_sub(input string req, input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc);
    int diff;
    apply(xa, xb, xc, 1'b1);
    diff = int'(xa) - int'(xb);
    expect_out(req, diff[W-1:0], (xa >= xb));
  endtask

  task automatic t_reset_state;
    apply('0, '0, 1'b0, 1'b0);
    expect_out("R1 zero operands", '0, 1'b0);
  endtask

  task automatic t_add_corners;
    run_add("R1 max plus max", 16'hFFFF, 16'hFFFF, 1'b1);
    run_add("R1 max plus one", 16'hFFFF, 16'h0001, 1'b0);
    run_add("R1 half words", 16'h8000, 16'h8000, 1'b0);
    run_add("R1 carry-in only", 16'h0000, 16'h0000, 1'b1);
    run_add("R1 alternating", 16'hAAAA, 16'h5555, 1'b1);
  endtask

  task automatic t_full_bypass_r5;
    apply(16'hFFFF, 16'h0000, 1'b1, 1'b0);
    expect_out("R5 full propagate ci=1", 16'h0000, 1'b1);
    apply(16'hFFFF, 16'h0000, 1'b0, 1'b0);
    expect_out("R5 full propagate ci=0", 16'hFFFF, 1'b0);
    // propagate pattern split across operands
    apply(16'hF0F0, 16'h0F0F, 1'b1, 1'b0);
    expect_out("R5 split propagate ci=1", 16'h0000, 1'b1);
  endtask

  task automatic t_group_owns_carry_r6;
    // Bit 3 generates, bits 4..15 propagate: carry out comes from group 0 irrespective of ci
    run_add("R6 generate in low group ci=0", 16'hFFF8, 16'h0008, 1'b0);
    run_add("R6 generate in low group ci=1", 16'hFFF8, 16'h0008, 1'b1);
    // Kill in top group: co stays 0 even though lower groups all propagate
    run_add("R6 kill in top group", 16'h0FFF, 16'h0000, 1'b1);
    // Mid-group generate inside the wide middle group of the non-uniform layout
    run_add("R6 mid generate", 16'h0100, 16'h0100, 1'b0);
  endtask

  task automatic t_gpk_r7;
    // Single-bit cases cover generate, propagate and kill at each position
    for (int i = 0; i < W; i++) begin
      run_add("R7 single bit generate", W'(1) << i, W'(1) << i, 1'b0);
      run_add("R7 single bit propagate", W'(1) << i, '0, 1'b1);
    end
  endtask

  task automatic t_sub_corners;
    run_sub("R2 equal operands", 16'h1234, 16'h1234, 1'b0);
    run_sub("R3 borrow zero minus one", 16'h0000, 16'h0001, 1'b0);
    run_sub("R3 max minus zero", 16'hFFFF, 16'h0000, 1'b0);
    run_sub("R2 zero minus max", 16'h0000, 16'hFFFF, 1'b0);
    run_sub("R3 one above", 16'h8001, 16'h8000, 1'b0);
  endtask

  task automatic t_sub_ignores_ci_r4;
    logic [W-1:0] s0, s0v;
    logic         c0, c0v;
    apply(16'h3C5A, 16'h7001, 1'b0, 1'b1);
    s0 = sum_u; c0 = co_u; s0v = sum_v; c0v = co_v;
    apply(16'h3C5A, 16'h7001, 1'b1, 1'b1);
    n_tests++;
    if (sum_u !== s0 || co_u !== c0 || sum_v !== s0v || co_v !== c0v) begin
      n_fail++;
      $display("FAIL R4 ci changed subtract result: got %h/%b %h/%b exp %h/%b %h/%b",
               sum_u, co_u, sum_v, co_v, s0, c0, s0v, c0v);
    end
    run_sub("R4 ci=1 subtract", 16'h3C5A, 16'h7001, 1'b1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      run_add("R1 random add", ra, rb, rc);
      run_sub("R2 R3 random subtract", ra, rb, rc);
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0; op_sub = 1'b0;
    void'($urandom(32'h5EED_0011));
    repeat (2) @(posedge clk);
    t_reset_state();
    t_add_corners();
    t_full_bypass_r5();
    t_group_owns_carry_r6();
    t_gpk_r7();
    t_sub_corners();
    t_sub_ignores_ci_r4();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule